// File: doc/BRIEF.md
# Cross-Port Error Notification Fabric

This block sits beside the ports of an N-port switch and lets every port learn that another port has seen an error. Within each port it merges the correctable and uncorrectable error indications of the port's functions into one status vector, one bit per error type. Hardware alone drives this vector. A bit follows its error condition and drops when the condition ends. Functions that the current operating mode leaves absent are shut out of the merge.

Each port has a mask register, writable by software, that picks which status bits may raise a notification. When any unmasked bit is set, the port flags itself to every other port. Each receiving port records the source's index in a sticky peer-error register, which software clears by writing ones. Each port then reports its set peer bits, together with its own local internal errors, on either a correctable or an uncorrectable internal-error output. A per-port severity input picks which one. The port's own internal-error status bit is fed only by errors that start inside that port, so two ports watching each other cannot drive each other in a loop.

A small register port reads and writes the masks and the peer-error registers. The address is the port index followed by one select bit.

Top module: `errnf_top`

## Requirements
- R1: Status bit e of port p (e other than the internal-error index) is 1 while any present function of port p asserts its correctable or uncorrectable input for type e. The input bit for port p, function f, type e sits at index (p*NUM_FUNCS+f)*NUM_ERR+e. The status bit is exposed at errStatus[p*NUM_ERR+e].
- R2: A function whose present bit (funcPresent[p*NUM_FUNCS+f]) is 0 has no effect on its port's status vector.
- R3: The internal-error status bit (index INT_ERR_IDX, default 0) follows only the port's localIntErr input. Function inputs at that index and the port's own peer-error bits never set it.
- R4: Status bits are transient. A bit returns to 0 in the same cycle that its error inputs drop, with no software action.
- R5: After reset every mask register reads all ones, so no port notifies even while errors are present. After reset every peer-error register reads 0.
- R6: portNotify[p] is 1 in the same cycle that any status bit of port p is set while its mask bit is 0.
- R7: At the first clock edge where portNotify[k] is 1, bit k of the peer-error register of every other port becomes 1. Bit p of port p's own peer-error register is never set.
- R8: Peer-error bits hold until software writes 1 to them. A write-1 clear in the same cycle as an active notification for that bit leaves the bit set.
- R9: A port reports on intErrUnc when sevUnc[p] is 1, and on intErrCor otherwise, whenever any of its peer-error bits or its localIntErr is set. The other output stays 0.
- R10: Register address {port, sel}: sel 0 selects the port's mask (read/write, bits NUM_ERR-1:0), sel 1 selects its peer-error register (read, write-1-to-clear, bits NUM_PORTS-1:0). Read data is combinational and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| funcCorErr | input | NUM_PORTS*NUM_FUNCS*NUM_ERR | Correctable error indications per port, function and type |
| funcUncErr | input | NUM_PORTS*NUM_FUNCS*NUM_ERR | Uncorrectable error indications per port, function and type |
| funcPresent | input | NUM_PORTS*NUM_FUNCS | Function present in the current operating mode |
| localIntErr | input | NUM_PORTS | Internal error that starts inside the port |
| sevUnc | input | NUM_PORTS | 1 routes the port's report to the uncorrectable output |
| regWe | input | 1 | Register write strobe |
| regAddr | input | $clog2(NUM_PORTS)+1 | {port index, select} |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data of the addressed register |
| errStatus | output | NUM_PORTS*NUM_ERR | Per-port transient status vectors |
| portNotify | output | NUM_PORTS | Port is broadcasting a notification |
| intErrCor | output | NUM_PORTS | Correctable internal-error report |
| intErrUnc | output | NUM_PORTS | Uncorrectable internal-error report |

## Verification
The bench uses the defaults: four ports, three functions per port and eight error types. Four ports mean that one broadcast reaches three peers at once, so the bench can see both the skipped self bit and a clear aimed at a single receiver. Three functions let one absent function be tested while others in the same port stay live. Eight types leave room for the internal-error index and several ordinary types side by side.

// File: rtl/errnf_pkg.sv
package errnf_pkg;
  // Strobes from the register decoder to the datapath.
  typedef struct packed {
    logic wrMask;   // write the addressed port's mask
    logic clrPeer;  // write-1-to-clear the addressed port's peer flags
    logic selPeer;  // read mux selects the peer register
  } regStb_t;
endpackage

// File: rtl/errnf_agg.sv
module errnf_agg #(
  parameter int NUM_FUNCS   = 3,
  parameter int NUM_ERR     = 8,
  parameter int INT_ERR_IDX = 0
) (
  input  logic [NUM_FUNCS*NUM_ERR-1:0] funcCor,
  input  logic [NUM_FUNCS*NUM_ERR-1:0] funcUnc,
  input  logic [NUM_FUNCS-1:0]         funcPresent,
  input  logic                         localIntErr,
  output logic [NUM_ERR-1:0]           status
);
  logic [NUM_ERR-1:0] merged;

  always_comb begin
    merged = '0;
    for (int f = 0; f < NUM_FUNCS; f++) begin
      if (funcPresent[f])
        merged = merged | funcCor[f*NUM_ERR +: NUM_ERR] | funcUnc[f*NUM_ERR +: NUM_ERR];
    end
    status = merged;
    // Internal-error type: only errors that start in this port count.
    status[INT_ERR_IDX] = localIntErr;
  end
endmodule

// File: rtl/errnf_ctrl.sv
module errnf_ctrl
  import errnf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [PSEL_W:0]   regAddr,
  output regStb_t           stb,
  output logic [PSEL_W-1:0] portSel,
  output logic              portValid
);
  logic selBit;

  assign portSel   = regAddr[PSEL_W:1];
  assign selBit    = regAddr[0];
  assign portValid = (int'(portSel) < NUM_PORTS);

  always_comb begin
    stb.selPeer = selBit;
    stb.wrMask  = regWe & ~selBit & portValid;
    stb.clrPeer = regWe &  selBit & portValid;
  end

  // R10: one write target per cycle at most.
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMask, stb.clrPeer}));
endmodule

// File: rtl/errnf_dp.sv
module errnf_dp
  import errnf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_ERR   = 8,
  parameter int DATA_W    = 8,
  parameter int PSEL_W    = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStb_t                      stb,
  input  logic [PSEL_W-1:0]            portSel,
  input  logic                         portValid,
  input  logic [DATA_W-1:0]            regWdata,
  input  logic [NUM_PORTS*NUM_ERR-1:0] status,
  input  logic [NUM_PORTS-1:0]         localIntErr,
  input  logic [NUM_PORTS-1:0]         sevUnc,
  output logic [DATA_W-1:0]            regRdata,
  output logic [NUM_PORTS-1:0]         notify,
  output logic [NUM_PORTS-1:0]         intErrCor,
  output logic [NUM_PORTS-1:0]         intErrUnc
);
  logic [NUM_ERR-1:0]   maskQ   [NUM_PORTS];
  logic [NUM_PORTS-1:0] peerQ   [NUM_PORTS];
  logic [NUM_PORTS-1:0] peerClr [NUM_PORTS];
  logic [NUM_PORTS-1:0] peerSet [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic addrHit;
    logic report;

    assign addrHit   = (portSel == PSEL_W'(p));
    assign notify[p] = |(status[p*NUM_ERR +: NUM_ERR] & ~maskQ[p]);
    // Broadcast to everyone except the port itself.
    assign peerSet[p] = notify & ~(NUM_PORTS'(1) << p);
    assign peerClr[p] = (stb.clrPeer && addrHit) ? regWdata[NUM_PORTS-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN)                      maskQ[p] <= '1;
      else if (stb.wrMask && addrHit) maskQ[p] <= regWdata[NUM_ERR-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) peerQ[p] <= '0;
      else       peerQ[p] <= (peerQ[p] & ~peerClr[p]) | peerSet[p];
    end

    assign report       = (|peerQ[p]) | localIntErr[p];
    assign intErrCor[p] = report & ~sevUnc[p];
    assign intErrUnc[p] = report &  sevUnc[p];

    // R7: a port never flags itself.
    p_no_self_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
      !peerQ[p][p]);
    // R9: any held peer flag yields a report on one of the two outputs.
    p_report_r9: assert property (@(posedge clk) disable iff (!rstN)
      (|peerQ[p]) |-> (intErrCor[p] ^ intErrUnc[p]));

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_src
      if (k != p) begin : g_peer
        // R7: notification from k lands in port p on the next edge.
        p_peer_set_r7: assert property (@(posedge clk) disable iff (!rstN)
          notify[k] |=> peerQ[p][k]);
        // R8: a flag stays until cleared by a write of one.
        p_peer_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
          (peerQ[p][k] && !peerClr[p][k]) |=> peerQ[p][k]);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (portValid) begin
      if (stb.selPeer) regRdata[NUM_PORTS-1:0] = peerQ[portSel];
      else             regRdata[NUM_ERR-1:0]   = maskQ[portSel];
    end
  end
endmodule

// File: rtl/errnf_top.sv
module errnf_top
  import errnf_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int NUM_FUNCS   = 3,
  parameter int NUM_ERR     = 8,
  parameter int INT_ERR_IDX = 0,
  parameter int DATA_W      = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_PORTS*NUM_FUNCS*NUM_ERR-1:0] funcCorErr,
  input  logic [NUM_PORTS*NUM_FUNCS*NUM_ERR-1:0] funcUncErr,
  input  logic [NUM_PORTS*NUM_FUNCS-1:0]         funcPresent,
  input  logic [NUM_PORTS-1:0]                   localIntErr,
  input  logic [NUM_PORTS-1:0]                   sevUnc,
  input  logic                                   regWe,
  input  logic [$clog2(NUM_PORTS):0]             regAddr,
  input  logic [DATA_W-1:0]                      regWdata,
  output logic [DATA_W-1:0]                      regRdata,
  output logic [NUM_PORTS*NUM_ERR-1:0]           errStatus,
  output logic [NUM_PORTS-1:0]                   portNotify,
  output logic [NUM_PORTS-1:0]                   intErrCor,
  output logic [NUM_PORTS-1:0]                   intErrUnc
);
  localparam int PSEL_W = $clog2(NUM_PORTS);
  localparam int SLICE  = NUM_FUNCS * NUM_ERR;

  regStb_t           stb;
  logic [PSEL_W-1:0] portSel;
  logic              portValid;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_agg
    errnf_agg #(
      .NUM_FUNCS  (NUM_FUNCS),
      .NUM_ERR    (NUM_ERR),
      .INT_ERR_IDX(INT_ERR_IDX)
    ) u_agg (
      .funcCor    (funcCorErr[p*SLICE +: SLICE]),
      .funcUnc    (funcUncErr[p*SLICE +: SLICE]),
      .funcPresent(funcPresent[p*NUM_FUNCS +: NUM_FUNCS]),
      .localIntErr(localIntErr[p]),
      .status     (errStatus[p*NUM_ERR +: NUM_ERR])
    );
  end

  errnf_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .PSEL_W   (PSEL_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .stb      (stb),
    .portSel  (portSel),
    .portValid(portValid)
  );

  errnf_dp #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_ERR  (NUM_ERR),
    .DATA_W   (DATA_W),
    .PSEL_W   (PSEL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .portSel    (portSel),
    .portValid  (portValid),
    .regWdata   (regWdata),
    .status     (errStatus),
    .localIntErr(localIntErr),
    .sevUnc     (sevUnc),
    .regRdata   (regRdata),
    .notify     (portNotify),
    .intErrCor  (intErrCor),
    .intErrUnc  (intErrUnc)
  );
endmodule

// File: tb/tb_errnf_top.sv
module tb_errnf_top;
  localparam int NP = 4, NF = 3, NE = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [NP*NF*NE-1:0] funcCorErr, funcUncErr;
  logic [NP*NF-1:0]    funcPresent;
  logic [NP-1:0]       localIntErr, sevUnc;
  logic                regWe;
  logic [2:0]          regAddr;
  logic [7:0]          regWdata, regRdata;
  logic [NP*NE-1:0]    errStatus;
  logic [NP-1:0]       portNotify, intErrCor, intErrUnc;

  int errCount = 0;
  int checkCount = 0;

  always #5 clk = ~clk;

  errnf_top dut (
    .clk(clk), .rstN(rstN), .funcCorErr(funcCorErr), .funcUncErr(funcUncErr),
    .funcPresent(funcPresent), .localIntErr(localIntErr), .sevUnc(sevUnc),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .errStatus(errStatus), .portNotify(portNotify),
    .intErrCor(intErrCor), .intErrUnc(intErrUnc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int port, input int sel, input logic [7:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'((port << 1) | sel); regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int port, input int sel, output logic [7:0] data);
    regAddr = 3'((port << 1) | sel);
    #1 data = regRdata;
  endtask

  function automatic int bitIdx(input int p, input int f, input int e);
    return (p*NF + f)*NE + e;
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    for (int p = 0; p < NP; p++) begin
      regRead(p, 0, d); chk("R5 mask reset", d, 8'hFF);
      regRead(p, 1, d); chk("R5 peer reset", d, 0);
    end
    @(negedge clk);
    funcCorErr[bitIdx(0, 0, 2)] = 1'b1;
    #1 chk("R5 masked no notify", portNotify, 0);
    @(negedge clk);
    regRead(1, 1, d); chk("R5 peer stays clear", d, 0);
    funcCorErr[bitIdx(0, 0, 2)] = 1'b0;
  endtask

  task automatic t_status;
    @(negedge clk);
    funcCorErr[bitIdx(2, 1, 3)] = 1'b1;
    #1 chk("R1 cor sets status", errStatus[2*NE+3], 1);
    funcCorErr[bitIdx(2, 1, 3)] = 1'b0;
    #1 chk("R4 status drops", errStatus[2*NE+3], 0);
    funcUncErr[bitIdx(2, 2, 5)] = 1'b1;
    #1 chk("R1 unc sets status", errStatus[2*NE+5], 1);
    chk("R1 other ports quiet", errStatus[NE-1:0], 0);
    funcUncErr[bitIdx(2, 2, 5)] = 1'b0;
    #1 chk("R4 unc drops", errStatus[2*NE+5], 0);
  endtask

  task automatic t_absent;
    @(negedge clk);
    funcPresent[0*NF+2] = 1'b0;
    funcCorErr[bitIdx(0, 2, 4)] = 1'b1;
    #1 chk("R2 absent func ignored", errStatus[0*NE+4], 0);
    funcCorErr[bitIdx(0, 0, 4)] = 1'b1;
    #1 chk("R2 present func counts", errStatus[0*NE+4], 1);
    funcCorErr[bitIdx(0, 2, 4)] = 1'b0;
    funcCorErr[bitIdx(0, 0, 4)] = 1'b0;
    funcPresent[0*NF+2] = 1'b1;
  endtask

  task automatic t_internal;
    @(negedge clk);
    funcUncErr[bitIdx(3, 0, 0)] = 1'b1;
    #1 chk("R3 func ignored at int idx", errStatus[3*NE+0], 0);
    funcUncErr[bitIdx(3, 0, 0)] = 1'b0;
    localIntErr[3] = 1'b1;
    #1 chk("R3 local int sets bit", errStatus[3*NE+0], 1);
    localIntErr[3] = 1'b0;
  endtask

  task automatic t_notify;
    logic [7:0] d;
    regWrite(1, 0, 8'hF7);
    regRead(1, 0, d); chk("R10 mask readback", d, 8'hF7);
    @(negedge clk);
    funcCorErr[bitIdx(1, 0, 3)] = 1'b1;
    #1 chk("R6 notify same cycle", portNotify, 4'b0010);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      regRead(p, 1, d);
      chk("R7 peer flag", d, (p == 1) ? 0 : 8'h02);
    end
    chk("R3 no feedback into int status", errStatus[2*NE+0], 0);
    // Set vs clear in the same cycle on port 3.
    regWrite(3, 1, 8'h02);
    regRead(3, 1, d); chk("R8 set wins over clear", d, 8'h02);
    @(negedge clk);
    funcCorErr[bitIdx(1, 0, 3)] = 1'b0;
    #1 chk("R6 notify drops", portNotify, 0);
    repeat (3) @(negedge clk);
    regRead(2, 1, d); chk("R8 sticky after source clears", d, 8'h02);
  endtask

  task automatic t_severity;
    @(negedge clk);
    sevUnc = 4'b0100;
    #1 chk("R9 unc route", intErrUnc, 4'b0101 & 4'b0100);
    chk("R9 cor route", intErrCor, 4'b1001);
    regWrite(0, 1, 8'h02);
    #1 chk("R9 cleared port quiet", {intErrUnc[0], intErrCor[0]}, 0);
    localIntErr[0] = 1'b1;
    #1 chk("R9 local int reports", intErrCor[0], 1);
    localIntErr[0] = 1'b0;
  endtask

  task automatic t_clear;
    logic [7:0] d;
    regWrite(3, 1, 8'h01);
    regRead(3, 1, d); chk("R8 write of 0 bit keeps flag", d, 8'h02);
    regWrite(3, 1, 8'h02);
    regRead(3, 1, d); chk("R8 w1c clears", d, 0);
    regRead(2, 1, d); chk("R10 clear targets one port", d, 8'h02);
  endtask

  initial begin
    #200000;
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; funcCorErr = '0; funcUncErr = '0; funcPresent = '1;
    localIntErr = '0; sevUnc = '0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_status();
    t_absent();
    t_internal();
    t_notify();
    t_severity();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end
endmodule